// File: doc/BRIEF.md
# Configuration Packet Stream Parser

This block sits behind a byte-wide configuration port and turns a raw byte stream into register commands. After reset, or after an external desynchronize request, it hunts for the 32-bit synchronization word 0xAA995566. Every byte that arrives before that word is dropped. Once the word is found, the block groups the following bytes into 32-bit words, with the first byte as the most significant. It reads each word either as a packet header or as payload for the packet that is currently open.

Two header formats are supported. The addressed format (type code 001) carries a 14-bit register address and a 13-bit word count. The extended format (type code 010) has no address field. It carries a 27-bit word count and reuses the address of the addressed header directly before it. A write packet produces one single-cycle write strobe per payload word. A read packet produces one request pulse that carries the address and the count. No-operation headers only take up time. Illegal header orders and unknown header types raise sticky error flags. The register file that consumes these strobes lies outside this block.

Top module: `cfg_pkt_parser`

## Requirements
- R1: Before the synchronization word has been seen, no input byte produces a write strobe or a read request, even if the bytes look like valid packets. `synced` rises on the cycle after the last byte of 0xAA995566 is accepted, and sync patterns that overlap each other are found.
- R2: After sync, each group of four accepted bytes forms one word, with the first byte in bits 31:24. Two write strobes are never on adjacent cycles.
- R3: The header type is in bits 31:29 and the opcode in bits 28:27 (00 no-op, 01 read, 10 write, 11 no access). A type 001 write header with address field bits 26:13 and count field bits 12:0 makes the next N words (N up to 4096 and beyond, within 13 bits) appear as N write strobes. Each strobe carries that address, and the address stays steady through the burst.
- R4: A type 001 write header with a count of zero produces no strobes. The next word is read as a header.
- R5: A type 010 header (count in bits 26:0) that directly follows a type 001 header with opcode read or write (or 11) uses that header's address. A write then yields count strobes, and a read yields one request carrying the 27-bit count.
- R6: A type 010 header is a sequence error if the previous header was not an eligible type 001 header. Cases include the first header after sync, another type 010 header, a no-op, or an unknown type. The error sets sticky `seq_err`, and the word has no other effect.
- R7: A type 001 no-op header produces no access and does not change the address. It does not make a following type 010 header legal.
- R8: A header with a type code other than 001 or 010 sets sticky `type_err` and is skipped. The next word is read as a header.
- R9: A read header produces exactly one `rd_req` pulse with `reg_addr` and `rd_count`, and consumes no payload words. `rd_req` and `reg_wr` are never high together.
- R10: A `desync` pulse clears `synced`, drops any partly assembled word and any open payload, and returns the parser to sync hunting. An input byte offered in the same cycle is discarded.
- R11: Out of reset, `synced`, `reg_wr`, `rd_req`, `seq_err` and `type_err` are low, and `in_ready` is high. The error flags are cleared only by reset and survive `desync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Configuration byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Byte is accepted this cycle (high out of reset) |
| desync | input | 1 | Return to sync hunting |
| synced | output | 1 | Word alignment established |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_wdata | output | 32 | Write data, valid with `reg_wr` |
| reg_addr | output | 14 | Target register address |
| rd_req | output | 1 | Single-cycle read request |
| rd_count | output | 27 | Word count of the read request |
| seq_err | output | 1 | Sticky: extended header out of order |
| type_err | output | 1 | Sticky: unknown header type |

## Verification
The hardest state to reach from the ports is a `desync` that arrives in the middle of a word or in the middle of an open write burst. After it, the next header must come from freshly aligned bytes, not from leftover bytes or leftover payload count. The stimulus gets there by stopping partway through a word and partway through a burst, pulsing `desync`, and sending a full packet that lacks a sync word, which must produce nothing. It then resyncs and checks that only the new packet's strobes appear. Random packet mixes with random byte gaps, a sync pattern that overlaps an earlier partial one, and a 4096-word burst cover alignment and counting.

// File: rtl/cfg_pkt_parser.sv
module cfg_pkt_parser #(
  parameter logic [31:0] SYNC_WORD = 32'hAA995566
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        desync,
  output logic        synced,
  output logic        reg_wr,
  output logic [31:0] reg_wdata,
  output logic [13:0] reg_addr,
  output logic        rd_req,
  output logic [26:0] rd_count,
  output logic        seq_err,
  output logic        type_err
);
  localparam logic [2:0] HT_ADDR = 3'b001;
  localparam logic [2:0] HT_EXT  = 3'b010;
  localparam logic [1:0] OP_NOP  = 2'b00;
  localparam logic [1:0] OP_RD   = 2'b01;
  localparam logic [1:0] OP_WR   = 2'b10;

  logic [31:0] hunt_q;
  logic [23:0] part_q;
  logic [1:0]  bcnt_q;
  logic        pay_q;
  logic [26:0] left_q;
  logic        t1_q;

  logic        take;
  logic [31:0] hunt_nx, word;
  logic [2:0]  htype;
  logic [1:0]  op;
  logic [12:0] cnt_s;
  logic [26:0] cnt_l;

  assign in_ready = rst_n;
  assign take     = in_valid && in_ready;
  assign hunt_nx  = {hunt_q[23:0], in_data};
  assign word     = {part_q, in_data};
  assign htype    = word[31:29];
  assign op       = word[28:27];
  assign cnt_s    = word[12:0];
  assign cnt_l    = word[26:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hunt_q    <= '0;
      part_q    <= '0;
      bcnt_q    <= '0;
      pay_q     <= 1'b0;
      left_q    <= '0;
      t1_q      <= 1'b0;
      synced    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
      reg_addr  <= '0;
      rd_req    <= 1'b0;
      rd_count  <= '0;
      seq_err   <= 1'b0;
      type_err  <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      rd_req <= 1'b0;
      if (desync) begin
        synced <= 1'b0;
        hunt_q <= '0;
        bcnt_q <= '0;
        pay_q  <= 1'b0;
        t1_q   <= 1'b0;
      end else if (take) begin
        if (!synced) begin
          hunt_q <= hunt_nx;
          if (hunt_nx == SYNC_WORD) begin
            synced <= 1'b1;
            bcnt_q <= '0;
          end
        end else begin
          bcnt_q <= bcnt_q + 2'd1;
          part_q <= {part_q[15:0], in_data};
          if (bcnt_q == 2'd3) begin
            if (pay_q) begin
              reg_wr    <= 1'b1;
              reg_wdata <= word;
              left_q    <= left_q - 27'd1;
              if (left_q == 27'd1) pay_q <= 1'b0;
            end else begin
              case (htype)
                HT_ADDR: begin
                  if (op != OP_NOP) begin
                    reg_addr <= word[26:13];
                    t1_q     <= 1'b1;
                  end else begin
                    t1_q     <= 1'b0;
                  end
                  if (op == OP_WR && cnt_s != 13'd0) begin
                    pay_q  <= 1'b1;
                    left_q <= {14'd0, cnt_s};
                  end
                  if (op == OP_RD) begin
                    rd_req   <= 1'b1;
                    rd_count <= {14'd0, cnt_s};
                  end
                end
                HT_EXT: begin
                  t1_q <= 1'b0;
                  if (!t1_q) begin
                    seq_err <= 1'b1;
                  end else begin
                    if (op == OP_WR && cnt_l != 27'd0) begin
                      pay_q  <= 1'b1;
                      left_q <= cnt_l;
                    end
                    if (op == OP_RD) begin
                      rd_req   <= 1'b1;
                      rd_count <= cnt_l;
                    end
                  end
                end
                default: begin
                  type_err <= 1'b1;
                  t1_q     <= 1'b0;
                end
              endcase
            end
          end
        end
      end
    end
  end

  // R1
  presync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |=> (!reg_wr && !rd_req));

  // R10
  wr_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || rd_req) |-> synced);

  // R2
  wr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R3
  burst_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && $past(rst_n)) |-> $stable(reg_addr));

  // R9
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr, rd_req}));

  // R6
  seq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);

  // R8
  type_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    type_err |=> type_err);

  // R11
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);
endmodule

// File: tb/cfg_pkt_parser_tb_top.sv
`timescale 1ns/1ps
module cfg_pkt_parser_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0;
  logic desync = 1'b0;
  logic in_ready, synced, reg_wr, rd_req, seq_err, type_err;
  logic [31:0] reg_wdata;
  logic [13:0] reg_addr;
  logic [26:0] rd_count;

  int n_chk = 0;
  int n_fail = 0;
  logic [45:0] got_wr[$], exp_wr[$];
  logic [40:0] got_rd[$], exp_rd[$];
  int gap_max = 0;

  always #2.5 clk = ~clk;

  cfg_pkt_parser dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .desync(desync), .synced(synced), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_addr(reg_addr), .rd_req(rd_req),
    .rd_count(rd_count), .seq_err(seq_err), .type_err(type_err));

  always @(negedge clk) if (rst_n) begin
    if (reg_wr) got_wr.push_back({reg_addr, reg_wdata});
    if (rd_req) got_rd.push_back({reg_addr, rd_count});
  end

  function automatic logic [31:0] h1(logic [1:0] op, logic [13:0] a, logic [12:0] c);
    return {3'b001, op, a, c};
  endfunction
  function automatic logic [31:0] h2(logic [1:0] op, logic [26:0] c);
    return {3'b010, op, c};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    in_data = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (gap_max > 0) repeat ($urandom_range(0, gap_max)) @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 3; i >= 0; i--) send_byte(w[i*8 +: 8]);
  endtask

  task automatic do_sync();
    send_word(32'hAA995566);
  endtask

  task automatic pulse_desync();
    desync = 1'b1;
    @(negedge clk);
    desync = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; desync = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    got_wr.delete(); got_rd.delete(); exp_wr.delete(); exp_rd.delete();
  endtask

  task automatic wr_pkt(input logic [13:0] a, input int n);
    send_word(h1(2'b10, a, n[12:0]));
    for (int i = 0; i < n; i++) begin
      logic [31:0] d = $urandom();
      exp_wr.push_back({a, d});
      send_word(d);
    end
  endtask

  task automatic cmp(input string req);
    int bad = 0;
    repeat (3) @(negedge clk);
    chk(got_wr.size() == exp_wr.size(), {req, " write count"}, got_wr.size(), exp_wr.size());
    chk(got_rd.size() == exp_rd.size(), {req, " read count"}, got_rd.size(), exp_rd.size());
    for (int i = 0; i < got_wr.size() && i < exp_wr.size(); i++)
      if (got_wr[i] !== exp_wr[i]) begin
        if (bad == 0) chk(1'b0, {req, " write entry"}, got_wr[i], exp_wr[i]);
        bad++;
      end
    for (int i = 0; i < got_rd.size() && i < exp_rd.size(); i++)
      if (got_rd[i] !== exp_rd[i]) begin
        if (bad == 0) chk(1'b0, {req, " read entry"}, got_rd[i], exp_rd[i]);
        bad++;
      end
    if (bad == 0) chk(1'b1, req, 0, 0);
    got_wr.delete(); got_rd.delete(); exp_wr.delete(); exp_rd.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R11 reset state
    chk({synced, reg_wr, rd_req, seq_err, type_err} == 5'b0, "R11 reset outputs",
        {synced, reg_wr, rd_req, seq_err, type_err}, 0);
    chk(in_ready == 1'b1, "R11 in_ready", in_ready, 1);

    // R1 junk and a packet-shaped stream before sync
    for (int i = 0; i < 40; i++) begin
      logic [7:0] b = $urandom_range(0, 255);
      if (b == 8'hAA) b = 8'h00;
      send_byte(b);
    end
    send_word(h1(2'b10, 14'h12, 13'd2)); send_word(32'h1); send_word(32'h2);
    send_word(h1(2'b01, 14'h3, 13'd1));
    send_byte(8'hAA); send_byte(8'h99); send_byte(8'h55);
    chk(synced == 1'b0, "R1 not synced before sync", synced, 0);
    cmp("R1 nothing before sync");
    do_sync();
    chk(synced == 1'b1, "R1 synced after overlapping sync", synced, 1);

    // R2 R3 byte order and burst
    send_word(h1(2'b10, 14'h0ABC, 13'd3));
    send_word(32'h11223344); exp_wr.push_back({14'h0ABC, 32'h11223344});
    send_word(32'hA0B0C0D0); exp_wr.push_back({14'h0ABC, 32'hA0B0C0D0});
    send_word(32'h00000001); exp_wr.push_back({14'h0ABC, 32'h00000001});
    cmp("R2 R3 big-endian burst");

    // R4 R5 zero count then extended header
    send_word(h1(2'b10, 14'h0155, 13'd0));
    repeat (3) @(negedge clk);
    chk(got_wr.size() == 0, "R4 zero count no strobe", got_wr.size(), 0);
    send_word(h2(2'b10, 27'd2));
    send_word(32'hCAFEF00D); exp_wr.push_back({14'h0155, 32'hCAFEF00D});
    send_word(32'h0BADBEEF); exp_wr.push_back({14'h0155, 32'h0BADBEEF});
    cmp("R5 extended write reuses address");
    chk(seq_err == 1'b0, "R5 no seq error", seq_err, 0);

    // R9 read headers
    send_word(h1(2'b01, 14'h0007, 13'd1)); exp_rd.push_back({14'h0007, 27'd1});
    send_word(h2(2'b01, 27'h4ABCDEF)); exp_rd.push_back({14'h0007, 27'h4ABCDEF});
    send_word(h1(2'b10, 14'h0009, 13'd1));
    send_word(32'h55AA55AA); exp_wr.push_back({14'h0009, 32'h55AA55AA});
    cmp("R9 read request and no payload");

    // R7 no-op keeps address and blocks extended header
    send_word(h1(2'b00, 14'h3FFF, 13'd0));
    send_word(h1(2'b00, 14'h3FFF, 13'd0));
    cmp("R7 no-op no access");
    send_word(h2(2'b10, 27'd1));
    repeat (2) @(negedge clk);
    chk(seq_err == 1'b1, "R7 R6 extended after no-op is error", seq_err, 1);
    send_word(h1(2'b01, 14'h0020, 13'd4)); exp_rd.push_back({14'h0020, 27'd4});
    cmp("R6 errored word skipped");

    // R8 unknown type skipped
    send_word(32'h60000000);
    send_word(h1(2'b10, 14'h0033, 13'd1));
    send_word(32'h12345678); exp_wr.push_back({14'h0033, 32'h12345678});
    cmp("R8 unknown type skipped");
    chk(type_err == 1'b1, "R8 type_err set", type_err, 1);

    // R10 desync mid-word and mid-burst
    send_byte(8'h30); send_byte(8'h00);
    pulse_desync();
    @(negedge clk);
    chk(synced == 1'b0, "R10 desync clears synced", synced, 0);
    chk({seq_err, type_err} == 2'b11, "R11 errors survive desync", {seq_err, type_err}, 3);
    send_word(h1(2'b10, 14'h0044, 13'd1)); send_word(32'hDEAD0001);
    cmp("R10 hunting after desync");
    do_sync();
    send_word(h1(2'b10, 14'h0050, 13'd3));
    send_word(32'h00000050); exp_wr.push_back({14'h0050, 32'h00000050});
    send_byte(8'h77);
    pulse_desync();
    do_sync();
    send_word(h1(2'b10, 14'h0051, 13'd1));
    send_word(32'h00000051); exp_wr.push_back({14'h0051, 32'h00000051});
    cmp("R10 burst dropped on desync");

    // R6 extended header first after sync and twice in a row
    do_reset();
    do_sync();
    send_word(h2(2'b10, 27'd1));
    repeat (2) @(negedge clk);
    chk(seq_err == 1'b1, "R6 extended first after sync", seq_err, 1);
    do_reset();
    chk(seq_err == 1'b0, "R11 reset clears seq_err", seq_err, 0);
    do_sync();
    send_word(h1(2'b10, 14'h0060, 13'd0));
    send_word(h2(2'b10, 27'd1));
    send_word(32'h60606060); exp_wr.push_back({14'h0060, 32'h60606060});
    send_word(h2(2'b10, 27'd1));
    repeat (2) @(negedge clk);
    chk(seq_err == 1'b1, "R6 two extended headers", seq_err, 1);
    cmp("R6 second extended skipped");

    // R3 4096-word burst
    do_reset();
    do_sync();
    wr_pkt(14'h0005, 4096);
    cmp("R3 4096-word burst");

    // random mix with byte gaps
    gap_max = 2;
    for (int p = 0; p < 30; p++) begin
      logic [13:0] a = $urandom();
      int kind = $urandom_range(0, 3);
      int n = $urandom_range(1, 5);
      if (kind == 0) wr_pkt(a, n);
      else if (kind == 1) begin
        send_word(h1(2'b10, a, 13'd0));
        send_word(h2(2'b10, n[26:0]));
        for (int i = 0; i < n; i++) begin
          logic [31:0] d = $urandom();
          exp_wr.push_back({a, d});
          send_word(d);
        end
      end else if (kind == 2) begin
        send_word(h1(2'b01, a, n[12:0])); exp_rd.push_back({a, n[26:0]});
      end else send_word(h1(2'b00, a, 13'd0));
    end
    gap_max = 0;
    cmp("R2 R3 R5 random packets");
    chk({seq_err, type_err} == 2'b00, "R6 R8 no errors in legal mix", {seq_err, type_err}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule